// File: doc/BRIEF.md
# Feature-control register write checker

This block owns a 32-bit processor feature-control register and screens every write made to it. Four capability inputs tell it which optional features the core implements. From them it builds, each cycle, the set of bits software may set. A write that sets any bit outside that set is refused: the register keeps its old contents and a one-cycle fault pulse goes to the exception logic. A write that passes updates the register.

When an accepted write changes any of the bits that steer address translation, the block pulses a request to flush the translation cache. Bits 4, 5, 7, 17 and 20 are the ones watched. In the same cycle it may also pulse a request to reload the cached table pointers. It does so when paging is on, the new value sets bit 5 (extended addressing), and the core is not in long mode. The flush itself, the reload and the fault delivery all happen outside this block.

Top module: `fcr_write_guard`

## Requirements
- R1: While reset is asserted, the register reads zero and the fault, flush and reload outputs are low.
- R2: A write of any value that uses only bits 15..0 is accepted, and the register shows it from the cycle after the write.
- R3: A write that sets bit 19 or any of bits 31..21 is rejected. The fault output goes high for the cycle after the write, and the register is unchanged.
- R4: Bit 20 (execution guard enable) may be set only while `cap_exec_guard` is high; otherwise the write is rejected as in R3.
- R5: Bit 18 (extended state enable) may be set only while `cap_xstate` is high; otherwise the write is rejected.
- R6: Bit 17 (context tag enable) is gated by `cap_ctx_tag`, and bit 16 (segment base access enable) is gated by `cap_seg_base`; setting either without its capability is rejected.
- R7: A rejected write raises neither the flush nor the reload output, whatever bits it would have changed.
- R8: The flush output is high for the cycle after an accepted write if the write changed any of bits 4, 5, 7, 17 or 20. It stays low when only other bits change, or when nothing changes.
- R9: The reload output is high in the same cycle as the flush, provided that at the write `paging_on` was high, `long_mode` was low, and the new value has bit 5 set. Otherwise it stays low.
- R10: Fault, flush and reload are single-cycle pulses. A cycle without a write leaves all three low and the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Value to write |
| cap_seg_base | input | 1 | Core supports segment base access (gates bit 16) |
| cap_ctx_tag | input | 1 | Core supports context tags (gates bit 17) |
| cap_xstate | input | 1 | Core supports extended state save (gates bit 18) |
| cap_exec_guard | input | 1 | Core supports supervisor execution guard (gates bit 20) |
| paging_on | input | 1 | Paging currently enabled |
| long_mode | input | 1 | Core is in long mode |
| reg_q | output | 32 | Current register value |
| wr_fault | output | 1 | One-cycle pulse: write rejected |
| xlat_flush | output | 1 | One-cycle pulse: flush translation cache |
| ptr_reload | output | 1 | One-cycle pulse: reload cached table pointers |

## Verification
Every result of a write comes out of one register stage. The new register value, the fault pulse, the flush pulse and the reload pulse all appear in the cycle after the edge that samples the strobe, and each lasts exactly that one cycle. The bench applies each stimulus after a falling edge and lets one rising edge pass. It then compares all four outputs against its own model at the next falling edge. Because the bench compares on idle cycles too, a pulse that lingers for a second cycle is caught.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned NUM_CAP = 4;

  // capability vector order: seg base, context tag, extended state, exec guard
  localparam int unsigned CAP_POS [NUM_CAP] = '{16, 17, 18, 20};

  // bits that every configuration may write
  localparam logic [REG_W-1:0] BASE_MASK = 32'h0000_FFFF;

  localparam int unsigned LPG_BIT    = 4;
  localparam int unsigned XADDR_BIT  = 5;
  localparam int unsigned GLB_BIT    = 7;
  localparam int unsigned CTX_BIT    = 17;
  localparam int unsigned XGUARD_BIT = 20;

  localparam logic [REG_W-1:0] FLUSH_MASK =
      (REG_W'(1) << LPG_BIT) | (REG_W'(1) << XADDR_BIT) | (REG_W'(1) << GLB_BIT) |
      (REG_W'(1) << CTX_BIT) | (REG_W'(1) << XGUARD_BIT);

  localparam logic [REG_W-1:0] CAP_ALL_MASK =
      (REG_W'(1) << CAP_POS[0]) | (REG_W'(1) << CAP_POS[1]) |
      (REG_W'(1) << CAP_POS[2]) | (REG_W'(1) << CAP_POS[3]);

  localparam logic [REG_W-1:0] RSVD_MASK = ~(BASE_MASK | CAP_ALL_MASK);
endpackage

// File: rtl/fcr_mask_gen.sv
module fcr_mask_gen #(
  parameter int unsigned W    = fcr_pkg::REG_W,
  parameter int unsigned NCAP = fcr_pkg::NUM_CAP
) (
  input  logic [NCAP-1:0] cap,
  output logic [W-1:0]    wr_mask
);
  logic [W-1:0] cap_bit [NCAP];

  for (genvar g = 0; g < NCAP; g++) begin : g_cap
    assign cap_bit[g] = cap[g] ? (W'(1) << fcr_pkg::CAP_POS[g]) : '0;
  end

  always_comb begin
    wr_mask = fcr_pkg::BASE_MASK;
    for (int i = 0; i < NCAP; i++) wr_mask = wr_mask | cap_bit[i];
  end
endmodule

// File: rtl/fcr_change_detect.sv
module fcr_change_detect #(
  parameter int unsigned W = fcr_pkg::REG_W
) (
  input  logic [W-1:0] cur_val,
  input  logic [W-1:0] new_val,
  input  logic         paging_on,
  input  logic         long_mode,
  output logic         flush_req,
  output logic         reload_req
);
  logic [W-1:0] diff;

  always_comb begin
    diff       = (cur_val ^ new_val) & fcr_pkg::FLUSH_MASK;
    flush_req  = |diff;
    reload_req = flush_req & paging_on & new_val[fcr_pkg::XADDR_BIT] & ~long_mode;
  end
endmodule

// File: rtl/fcr_state.sv
module fcr_state #(
  parameter int unsigned W = fcr_pkg::REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] wr_mask,
  input  logic         flush_req,
  input  logic         reload_req,
  output logic [W-1:0] reg_q,
  output logic         fault_q,
  output logic         flush_q,
  output logic         reload_q
);
  logic         illegal;
  logic         accept;
  logic         reg_en;
  logic [W-1:0] reg_d;
  logic         fault_d, flush_d, reload_d;

  always_comb begin
    illegal  = |(wr_data & ~wr_mask);
    accept   = wr_en & ~illegal;
    reg_en   = accept;
    reg_d    = wr_data;
    fault_d  = wr_en & illegal;
    flush_d  = accept & flush_req;
    reload_d = accept & reload_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (reg_en) begin
      reg_q <= reg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q  <= 1'b0;
      flush_q  <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      fault_q  <= fault_d;
      flush_q  <= flush_d;
      reload_q <= reload_d;
    end
  end
endmodule

// File: rtl/fcr_write_guard.sv
module fcr_write_guard
  import fcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cap_seg_base,
  input  logic             cap_ctx_tag,
  input  logic             cap_xstate,
  input  logic             cap_exec_guard,
  input  logic             paging_on,
  input  logic             long_mode,
  output logic [REG_W-1:0] reg_q,
  output logic             wr_fault,
  output logic             xlat_flush,
  output logic             ptr_reload
);
  logic [NUM_CAP-1:0] cap_vec;
  logic [REG_W-1:0]   wr_mask;
  logic               flush_req, reload_req;

  assign cap_vec = {cap_exec_guard, cap_xstate, cap_ctx_tag, cap_seg_base};

  fcr_mask_gen #(.W(REG_W), .NCAP(NUM_CAP)) mask_i (
    .cap     (cap_vec),
    .wr_mask (wr_mask)
  );

  fcr_change_detect #(.W(REG_W)) chg_i (
    .cur_val    (reg_q),
    .new_val    (wr_data),
    .paging_on  (paging_on),
    .long_mode  (long_mode),
    .flush_req  (flush_req),
    .reload_req (reload_req)
  );

  fcr_state #(.W(REG_W)) st_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wr_mask    (wr_mask),
    .flush_req  (flush_req),
    .reload_req (reload_req),
    .reg_q      (reg_q),
    .fault_q    (wr_fault),
    .flush_q    (xlat_flush),
    .reload_q   (ptr_reload)
  );
endmodule

// File: rtl/fcr_write_guard_chk.sv
module fcr_write_guard_chk
  import fcr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             cap_exec_guard,
  input logic [REG_W-1:0] reg_q,
  input logic             wr_fault,
  input logic             xlat_flush,
  input logic             ptr_reload
);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (reg_q == '0 && !wr_fault && !xlat_flush && !ptr_reload));

  assert_reserved_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && |(wr_data & RSVD_MASK)) |=> (wr_fault && $stable(reg_q)));

  assert_exec_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[XGUARD_BIT] && !cap_exec_guard) |=> wr_fault);

  assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> (!xlat_flush && !ptr_reload));

  assert_flush_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_flush |-> ((reg_q & FLUSH_MASK) != ($past(reg_q) & FLUSH_MASK)));

  assert_reload_with_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_reload |-> (xlat_flush && reg_q[XADDR_BIT]));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(reg_q) && !wr_fault && !xlat_flush && !ptr_reload));
endmodule

bind fcr_write_guard fcr_write_guard_chk chk_i (.*);

// File: tb/fcr_write_guard_tb_top.sv
module fcr_write_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        cap_seg_base, cap_ctx_tag, cap_xstate, cap_exec_guard;
  logic        paging_on, long_mode;
  logic [31:0] reg_q;
  logic        wr_fault, xlat_flush, ptr_reload;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [31:0] m_reg;
  bit          m_fault, m_flush, m_reload;

  always #4 clk = ~clk;

  fcr_write_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cap_seg_base(cap_seg_base), .cap_ctx_tag(cap_ctx_tag),
    .cap_xstate(cap_xstate), .cap_exec_guard(cap_exec_guard),
    .paging_on(paging_on), .long_mode(long_mode),
    .reg_q(reg_q), .wr_fault(wr_fault), .xlat_flush(xlat_flush),
    .ptr_reload(ptr_reload)
  );

  function automatic bit may_set(int b);
    if (b <= 15) return 1'b1;
    case (b)
      16: return cap_seg_base;
      17: return cap_ctx_tag;
      18: return cap_xstate;
      20: return cap_exec_guard;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "reg_q", reg_q, m_reg);
    chk(tag, "wr_fault", 32'(wr_fault), 32'(m_fault));
    chk(tag, "xlat_flush", 32'(xlat_flush), 32'(m_flush));
    chk(tag, "ptr_reload", 32'(ptr_reload), 32'(m_reload));
  endtask

  // drive one cycle after a falling edge, compare at the next falling edge
  task automatic step(bit we, logic [31:0] d, string tag);
    bit bad = 0;
    bit changed = 0;
    int watch[$] = '{4, 5, 7, 17, 20};
    wr_en   = we;
    wr_data = d;
    m_fault = 0; m_flush = 0; m_reload = 0;
    if (we) begin
      for (int b = 0; b < 32; b++) if (d[b] && !may_set(b)) bad = 1;
      if (bad) m_fault = 1;
      else begin
        foreach (watch[k]) if (d[watch[k]] != m_reg[watch[k]]) changed = 1;
        m_flush  = changed;
        m_reload = changed && paging_on && !long_mode && d[5];
        m_reg    = d;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_data = '0;
    cap_seg_base = 0; cap_ctx_tag = 0; cap_xstate = 0; cap_exec_guard = 0;
    paging_on = 0; long_mode = 0;
    m_reg = '0; m_fault = 0; m_flush = 0; m_reload = 0;
    repeat (3) @(negedge clk);
    wr_en = 1; wr_data = 32'hFFFF_FFFF;       // ignored during reset
    @(negedge clk);
    compare_all("R1");
    wr_en = 0;
    rst_n = 1;
    @(negedge clk);
    compare_all("R1");

    step(1, 32'h0000_00B0, "R8");            // sets 4,5,7: flush, paging off
    step(1, 32'h0000_00B0, "R8");            // same value: no flush
    step(1, 32'h0000_00B1, "R2");            // bit 0 only
    step(1, 32'h0000_A5B1, "R2");            // low bits, no watched change
    step(0, 32'hFFFF_FFFF, "R10");           // idle
    step(1, 32'h0008_00B1, "R3");            // bit 19
    step(1, 32'h8000_00B1, "R3");            // bit 31
    step(1, 32'h0020_00A0, "R7");            // bit 21 + changes bit 4: reject, no flush
    step(1, 32'h0010_00B1, "R4");            // no cap
    step(1, 32'h0004_00B1, "R5");
    step(1, 32'h0002_00B1, "R6");
    step(1, 32'h0001_00B1, "R6");

    cap_seg_base = 1; cap_ctx_tag = 1; cap_xstate = 1; cap_exec_guard = 1;
    paging_on = 1; long_mode = 0;
    step(1, 32'h0010_00B1, "R4");            // bit 20: flush + reload
    step(1, 32'h0014_00B1, "R5");            // bit 18: not watched
    step(1, 32'h0015_00B1, "R6");            // bit 16: not watched
    step(1, 32'h0017_00B1, "R9");            // bit 17: flush + reload
    step(0, 32'h0, "R10");
    long_mode = 1;
    step(1, 32'h0017_0031, "R9");            // clear 7 in long mode: no reload
    long_mode = 0;
    step(1, 32'h0017_0011, "R9");            // clear 5: new bit5 = 0, no reload
    paging_on = 0;
    step(1, 32'h0017_0031, "R9");            // set 5, paging off: no reload
    paging_on = 1;
    step(1, 32'h0007_0031, "R8");            // clear 20
    step(1, 32'h0017_0031, "R10");           // back-to-back: flush+reload
    step(1, 32'h0017_0031, "R10");           // identical: pulses drop
    cap_exec_guard = 0;
    step(1, 32'h0017_0021, "R4");            // bit 20 set without cap
    step(0, 32'h0, "R10");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule